// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves the operand of an already decoded instruction. The decoder supplies a 3-bit addressing-mode code and the 12-bit address or displacement field of the instruction, then raises `start` for one cycle. The unit reads one register through a combinational register-file read port. Where the mode calls for it, the unit adds that register to the field or uses the register as a pointer. It then issues one or two reads on a synchronous single-port memory, which returns data one cycle after the request.

When the value is known, the unit raises `done` for one cycle. It presents the operand that goes to the accumulator, and the effective address when the mode has one. Modes with no memory access finish one cycle after `start`. Modes with one read finish after two cycles. The memory-indirect form, which chains two dependent reads, finishes after three cycles. A small sequencer tracks these cycles and refuses new work until it is idle again.

Top module: `opfetch_unit`

## Requirements
- R1: Mode code 0 (immediate): `operand` is the field zero-extended, `ea` is 0, `mem_en` stays low, and `done` rises one cycle after the accepted start.
- R2: Mode code 1 (direct): `ea` equals the field, `operand` is the memory word at that address, and `done` rises two cycles after start. Read data is valid one cycle after `mem_en`.
- R3: Mode code 2 (register): `operand` is the register selected by the low RSEL bits of the field, `ea` is 0, no memory read occurs, and `done` rises one cycle after start.
- R4: Mode code 3 (memory-indirect): the word at the field address supplies, through its low 12 bits, the `ea`. `operand` is the word at that `ea`, and `done` rises three cycles after start.
- R5: Mode code 4 (register-indirect): `ea` is the low 12 bits of the register selected by the field's low bits, `operand` is the word there, and `done` comes after two cycles.
- R6: Mode code 5 (indexed): `ea` is the field plus index register IDX_REG (default 1), modulo 4096. `operand` is the word at `ea`, and `done` comes after two cycles.
- R7: Mode code 6 (based): `ea` is base register BASE_REG (default 2) plus the field as a displacement, modulo 4096. `operand` is the word at `ea`, and `done` comes after two cycles.
- R8: Mode code 7 (stack top): `ea` is the low 12 bits of stack register SP_REG (default NREG-1) whatever the field holds. `operand` is the word there, and `done` comes after two cycles.
- R9: A start raised while `busy` is high is ignored. The running fetch completes with its own result, and no extra `done` follows.
- R10: `done` is high for exactly one cycle per accepted start. `operand` and `ea` hold their values from `done` until the next accepted start.
- R11: After reset, `busy`, `done`, `mem_en`, `operand` and `ea` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| mode | input | 3 | Addressing-mode code |
| field | input | AW | Address / displacement / register field |
| rf_sel | output | RSEL | Register-file read select |
| rf_data | input | DW | Register-file read data (combinational) |
| mem_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Memory read data, one cycle after request |
| busy | output | 1 | A multi-cycle fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | DW | Value for the accumulator |
| ea | output | AW | Effective address (0 for immediate and register modes) |

## Verification
The bench builds the unit with AW=12, DW=16 and NREG=16, with index, base and stack registers 1, 2 and 15. A full 4096-word memory model therefore covers every address the field can name. Placing base and index values near the top of the space brings the modulo-4096 wrap of address arithmetic within reach. Register values carry nonzero upper bits, so truncation to 12 address bits is exercised. Indirect pointers whose upper bits differ from the target also show that only the low bits form the second address.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_REG  = 3'd2,
    AM_IND  = 3'd3,
    AM_RIND = 3'd4,
    AM_IDX  = 3'd5,
    AM_BASE = 3'd6,
    AM_STK  = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2
  } fstate_e;

  function automatic logic mode_reads_mem(amode_e m);
    return !(m == AM_IMM || m == AM_REG);
  endfunction
endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
  import opf_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NREG     = 16,
  parameter int IDX_REG  = 1,
  parameter int BASE_REG = 2,
  parameter int SP_REG   = NREG - 1,
  localparam int RSEL    = $clog2(NREG)
) (
  input  amode_e            mode_i,
  input  logic [AW-1:0]     field_i,
  input  logic [AW-1:0]     reg_lo_i,
  output logic [RSEL-1:0]   rsel_o,
  output logic [AW-1:0]     ea_o
);
  localparam logic [RSEL-1:0] IDX_SEL  = RSEL'(IDX_REG);
  localparam logic [RSEL-1:0] BASE_SEL = RSEL'(BASE_REG);
  localparam logic [RSEL-1:0] SP_SEL   = RSEL'(SP_REG);

  logic [AW-1:0] sum;
  assign sum = field_i + reg_lo_i;

  always_comb begin
    unique case (mode_i)
      AM_REG, AM_RIND: rsel_o = field_i[RSEL-1:0];
      AM_IDX:          rsel_o = IDX_SEL;
      AM_BASE:         rsel_o = BASE_SEL;
      AM_STK:          rsel_o = SP_SEL;
      default:         rsel_o = '0;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      AM_DIR, AM_IND:  ea_o = field_i;
      AM_RIND, AM_STK: ea_o = reg_lo_i;
      AM_IDX, AM_BASE: ea_o = sum;
      default:         ea_o = '0;
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  input  amode_e  mode_i,
  output logic    accept_o,
  output logic    first_rd_o,
  output logic    second_rd_o,
  output logic    cap_mem_o,
  output logic    finish_o,
  output logic    busy_o
);
  fstate_e st_q, st_d;
  amode_e  mode_q;

  assign accept_o    = start_i && (st_q == ST_IDLE);
  assign first_rd_o  = accept_o && mode_reads_mem(mode_i);
  assign second_rd_o = (st_q == ST_RD1) && (mode_q == AM_IND);
  assign cap_mem_o   = ((st_q == ST_RD1) && (mode_q != AM_IND)) || (st_q == ST_RD2);
  assign finish_o    = (accept_o && !mode_reads_mem(mode_i)) || cap_mem_o;
  assign busy_o      = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (first_rd_o) st_d = ST_RD1;
      ST_RD1:  st_d = second_rd_o ? ST_RD2 : ST_IDLE;
      ST_RD2:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_IMM;
    end else begin
      st_q <= st_d;
      if (accept_o) mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
  import opf_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int NREG     = 16,
  parameter int IDX_REG  = 1,
  parameter int BASE_REG = 2,
  parameter int SP_REG   = NREG - 1,
  localparam int RSEL    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [AW-1:0]   field,
  output logic [RSEL-1:0] rf_sel,
  input  logic [DW-1:0]   rf_data,
  output logic            mem_en,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   operand,
  output logic [AW-1:0]   ea
);
  amode_e        mode_e;
  logic [AW-1:0] ea_first;
  logic          accept, first_rd, second_rd, cap_mem, finish;

  assign mode_e = amode_e'(mode);

  opf_addr_gen #(
    .AW(AW), .NREG(NREG), .IDX_REG(IDX_REG), .BASE_REG(BASE_REG), .SP_REG(SP_REG)
  ) u_agen (
    .mode_i   (mode_e),
    .field_i  (field),
    .reg_lo_i (rf_data[AW-1:0]),
    .rsel_o   (rf_sel),
    .ea_o     (ea_first)
  );

  opf_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .mode_i      (mode_e),
    .accept_o    (accept),
    .first_rd_o  (first_rd),
    .second_rd_o (second_rd),
    .cap_mem_o   (cap_mem),
    .finish_o    (finish),
    .busy_o      (busy)
  );

  assign mem_en   = first_rd || second_rd;
  assign mem_addr = second_rd ? mem_rdata[AW-1:0] : ea_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      operand <= '0;
      ea      <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        ea <= ea_first;
        if (mode_e == AM_IMM) operand <= DW'(field);
        else if (mode_e == AM_REG) operand <= rf_data;
      end
      if (second_rd) ea <= mem_rdata[AW-1:0];
      if (cap_mem) operand <= mem_rdata;
    end
  end
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    mode,
  input logic [AW-1:0] field,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] operand,
  input logic [AW-1:0] ea
);
  a_r1_imm_no_read: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 3'd0) |-> !mem_en);

  a_r3_reg_no_read: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 3'd2) |-> !mem_en);

  a_r2_direct_addr: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 3'd1) |-> (mem_en && mem_addr == field));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(operand) && $stable(ea)));

  a_r9_busy_bound: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  a_r9_no_done_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind opfetch_unit opf_checker #(.AW(AW), .DW(DW)) u_opf_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .field(field),
  .mem_en(mem_en), .mem_addr(mem_addr), .busy(busy), .done(done),
  .operand(operand), .ea(ea)
);

// File: tb/opfetch_unit_test.sv
module opfetch_unit_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NREG = 16;
  localparam int RSEL = $clog2(NREG);
  localparam int NVEC = 12;
  // each entry: {mode[2:0], field[11:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {3'd0, 12'hABC}, {3'd0, 12'h000}, {3'd1, 12'h008}, {3'd1, 12'hFFF},
    {3'd2, 12'h004}, {3'd2, 12'h31F}, {3'd3, 12'h008}, {3'd4, 12'h004},
    {3'd5, 12'h100}, {3'd6, 12'h003}, {3'd7, 12'h777}, {3'd3, 12'hFFE}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] mode = '0;
  logic [AW-1:0] field = '0;
  logic [RSEL-1:0] rf_sel;
  logic [DW-1:0] rf_data, mem_rdata, operand;
  logic mem_en, busy, done;
  logic [AW-1:0] mem_addr, ea;
  logic [DW-1:0] mem [4096];
  logic [DW-1:0] regs [NREG];
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  assign rf_data = regs[rf_sel];
  always @(posedge clk) if (mem_en) mem_rdata <= mem[mem_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  opfetch_unit #(.AW(AW), .DW(DW), .NREG(NREG), .IDX_REG(1), .BASE_REG(2), .SP_REG(15)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .field(field),
    .rf_sel(rf_sel), .rf_data(rf_data), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .operand(operand), .ea(ea)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_ea(logic [2:0] m, logic [AW-1:0] f);
    case (m)
      3'd1: return f;
      3'd3: return mem[f][AW-1:0];
      3'd4: return regs[f[RSEL-1:0]][AW-1:0];
      3'd5: return f + regs[1][AW-1:0];
      3'd6: return regs[2][AW-1:0] + f;
      3'd7: return regs[15][AW-1:0];
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_op(logic [2:0] m, logic [AW-1:0] f);
    if (m == 3'd0) return DW'(f);
    if (m == 3'd2) return regs[f[RSEL-1:0]];
    return mem[exp_ea(m, f)];
  endfunction

  function automatic int exp_lat(logic [2:0] m);
    if (m == 3'd0 || m == 3'd2) return 1;
    if (m == 3'd3) return 3;
    return 2;
  endfunction

  // drive one fetch; returns cycles from start edge to done
  task automatic fetch(logic [2:0] m, logic [AW-1:0] f, output int lat, output logic saw_mem);
    @(negedge clk);
    start = 1'b1; mode = m; field = f;
    #1 saw_mem = mem_en;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic sm;
    for (int a = 0; a < 4096; a++) mem[a] = DW'(a * 37 + 16'h5123);
    mem[12'h008] = 16'h72A0;
    mem[12'h2A0] = 16'hBEEF;
    mem[12'hFFE] = 16'h0001;
    for (int i = 0; i < NREG; i++) regs[i] = DW'(i * 16'h0111 + 16'hA000);
    regs[1] = 16'h4F80;
    regs[2] = 16'hAFF0;
    regs[4] = 16'h3123;
    regs[15] = 16'h9800;

    repeat (3) @(negedge clk);
    chk("R11 busy", busy, 0); chk("R11 done", done, 0);
    chk("R11 mem_en", mem_en, 0); chk("R11 operand", operand, 0); chk("R11 ea", ea, 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] m;
      logic [AW-1:0] f;
      m = VEC[v][14:12]; f = VEC[v][11:0];
      fetch(m, f, lat, sm);
      chk({req_of(m), " latency"}, lat, exp_lat(m));
      chk({req_of(m), " operand"}, operand, exp_op(m, f));
      chk({req_of(m), " ea"}, ea, exp_ea(m, f));
      chk({req_of(m), " mem_en at start"}, sm, (m != 3'd0 && m != 3'd2));
      @(negedge clk);
      chk("R10 done single cycle", done, 0);
      chk("R10 operand held", operand, exp_op(m, f));
      chk("R10 ea held", ea, exp_ea(m, f));
    end

    // R6/R7 wrap at 4096
    fetch(3'd6, 12'h020, lat, sm);
    chk("R7 wrap ea", ea, 12'h010);
    fetch(3'd5, 12'h0A0, lat, sm);
    chk("R6 wrap ea", ea, 12'h020);
    // R8: field does not matter
    fetch(3'd7, 12'h123, lat, sm);
    chk("R8 field ignored", ea, 12'h800);

    // R9: start while busy is ignored
    @(negedge clk);
    start = 1'b1; mode = 3'd3; field = 12'h008;
    @(negedge clk);
    chk("R9 busy after start", busy, 1);
    mode = 3'd0; field = 12'h555;
    @(negedge clk);
    start = 1'b0;
    chk("R9 no early done", done, 0);
    @(negedge clk);
    chk("R9 done for original", done, 1);
    chk("R9 operand of original", operand, 16'hBEEF);
    chk("R9 ea of original", ea, 12'h2A0);
    @(negedge clk);
    chk("R9 no extra done", done, 0);
    chk("R9 operand kept", operand, 16'hBEEF);

    // R1 back-to-back immediates taken in done cycle
    @(negedge clk);
    start = 1'b1; mode = 3'd0; field = 12'h111;
    @(negedge clk);
    chk("R1 first imm done", done, 1);
    field = 12'h222;
    @(negedge clk);
    start = 1'b0;
    chk("R1 second imm done", done, 1);
    chk("R1 second imm operand", operand, 16'h0222);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule